// File: doc/BRIEF.md
# Multi-channel converter scan sequencer

This block is the digital control of an eight-input analog-to-digital converter. It reads a set of control fields: a channel mask, a clock divider, a burst enable, a resolution code and a start code. From the bus clock it makes a converter clock enable. It then runs either one conversion per software start or an endless scan over the selected inputs. The analog side is modelled as one sample word per input. Each sample is held when its conversion begins.

Each conversion lasts a number of converter clocks set by the resolution code. When it ends, the block presents the result for one cycle, right-aligned and cut to the chosen width, together with the channel it came from. A per-channel done flag records every finished conversion. A per-channel overrun flag records a result that replaced one nobody had cleared. A strobe on `rd_clr` clears both flags of a channel once its result has been taken.

Top module: `adc_scan_seq`

## Requirements
- R1: While reset is low, and after reset is released, `busy`, `res_valid`, `res_data`, `res_chan`, `cur_chan`, `done_flags` and `ovr_flags` read zero.
- R2: `conv_tick` is high for one bus cycle in every `ctrl_div`+1 cycles. With `ctrl_div` = 0 it is high on every cycle.
- R3: With `ctrl_burst` = 0, a change of `ctrl_start` to the value 3'b001 from any other value starts one conversion of the lowest set bit of `ctrl_mask`.
- R4: A conversion ends on the (11 − `ctrl_res`)-th `conv_tick` after the edge that starts it. `res_valid` is high in the cycle after that edge. With `ctrl_div` = 0 this is 11 − `ctrl_res` cycles after the start edge.
- R5: `res_data` holds the held sample of width 10 shifted right by `ctrl_res`. Its upper `ctrl_res` bits are zero, so the result has 10 − `ctrl_res` bits.
- R6: With `ctrl_burst` = 1 and `ctrl_start` = 0, conversions run back to back. The first one uses the lowest set mask bit. Each later one uses the next higher set bit, and the scan wraps to the lowest set bit after the highest.
- R7: An all-zero `ctrl_mask` selects channel 0.
- R8: While `ctrl_burst` = 1 and `ctrl_start` is non-zero, no conversion starts. Setting `ctrl_start` to 0 then starts the scan.
- R9: Clearing `ctrl_burst` during a conversion lets that conversion finish and report its result. After that no further conversion starts.
- R10: A mask change does not affect the conversion in progress. It applies when the next channel is chosen.
- R11: A result for channel c sets `done_flags`[c]. If that flag was already set, the result also sets `ovr_flags`[c]. `rd_clr`[c] clears both flags.
- R12: A start code held at 3'b001 after its conversion does not start another one. A start given while a conversion runs is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| ctrl_mask | input | 8 | Channel select mask, bit i selects input i |
| ctrl_div | input | 8 | Converter clock divider, period is value+1 bus cycles |
| ctrl_burst | input | 1 | Continuous scan enable |
| ctrl_res | input | 3 | Resolution code: 11−code clocks, 10−code bits |
| ctrl_start | input | 3 | Start code; 3'b001 starts a software conversion |
| ain | input | 80 | Sample words, input i at bits [10i+9:10i] |
| rd_clr | input | 8 | Per-channel clear of done and overrun flags |
| conv_tick | output | 1 | Converter clock enable |
| busy | output | 1 | A conversion is in progress |
| cur_chan | output | 3 | Channel being converted |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 10 | Right-aligned, truncated result |
| res_chan | output | 3 | Channel of the presented result |
| done_flags | output | 8 | Per-channel result-present flags |
| ovr_flags | output | 8 | Per-channel overrun flags |

## Verification
With a divider of zero, a result strobe is due exactly 11 − code cycles after the edge that starts its conversion. In a burst the next strobe follows the previous one by that same count, because the next conversion starts on the edge that ends the current one. The bench drives on falling edges and counts falling edges from the stimulus to the first strobe. It expects the count to be one more than the conversion length. With a divider of three it accepts only the window that divider phasing allows. Flags are read one falling edge after the strobe or clear that changes them.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_CONV = 1'b1
   } conv_st_e;

   // converter clocks per conversion for a sample width and resolution code
   function automatic int unsigned conv_clocks(input int unsigned sw,
                                               input int unsigned code);
      return sw + 1 - code;
   endfunction

   // bits kept in the result for a sample width and resolution code
   function automatic int unsigned conv_bits(input int unsigned sw,
                                             input int unsigned code);
      return sw - code;
   endfunction

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
   parameter int DIVW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [DIVW-1:0] div,
   output logic            tick
);
   logic [DIVW-1:0] cnt;

   assign tick = (cnt >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cnt <= '0;
      else if (tick)  cnt <= '0;
      else            cnt <= cnt + 1'b1;
   end

   // R2: with a non-zero, steady divider a tick is never followed by another
   a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && div != '0 && $stable(div)) |=> !tick);

endmodule

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
   parameter int NCH = 8,
   localparam int CHW = $clog2(NCH)
) (
   input  logic [NCH-1:0] mask,
   input  logic [CHW-1:0] prev,
   input  logic           first,
   output logic [CHW-1:0] pick
);
   logic [NCH-1:0] eff;
   logic [CHW-1:0] lo;
   logic [CHW-1:0] nxt;
   logic           got_lo;
   logic           got_nxt;

   always_comb begin
      eff     = (mask == '0) ? NCH'(1) : mask;
      lo      = '0;
      got_lo  = 1'b0;
      for (int i = 0; i < NCH; i++) begin
         if (eff[i] && !got_lo) begin
            lo     = CHW'(i);
            got_lo = 1'b1;
         end
      end
      nxt     = lo;
      got_nxt = 1'b0;
      for (int i = 0; i < NCH; i++) begin
         if (eff[i] && !got_nxt && i > int'(prev)) begin
            nxt     = CHW'(i);
            got_nxt = 1'b1;
         end
      end
      pick = first ? lo : nxt;
   end

   // R7: an empty mask can only yield channel 0
   a_r7_empty_mask: assert final (mask != '0 || pick == '0);

endmodule

// File: rtl/adc_conv_core.sv
module adc_conv_core
   import adc_seq_pkg::*;
#(
   parameter int NCH  = 8,
   parameter int SW   = 10,
   parameter int RESW = 3,
   parameter int STW  = 3,
   localparam int CHW = $clog2(NCH),
   localparam int LW  = $clog2(SW + 2)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            burst,
   input  logic [RESW-1:0] res,
   input  logic [STW-1:0]  start,
   input  logic [NCH*SW-1:0] ain,
   input  logic [CHW-1:0]  pick,
   output logic            busy,
   output logic [CHW-1:0]  cur_chan,
   output logic            res_valid,
   output logic [SW-1:0]   res_data,
   output logic [CHW-1:0]  res_chan
);
   localparam logic [STW-1:0] GO_CODE = STW'(1);

   conv_st_e        st;
   logic [STW-1:0]  start_q;
   logic [LW-1:0]   left;
   logic [RESW-1:0] res_q;
   logic [SW-1:0]   held;
   logic            sw_go;
   logic            burst_go;
   logic            done_now;
   logic            launch;

   assign busy     = (st == ST_CONV);
   assign sw_go    = !burst && start == GO_CODE && start_q != GO_CODE;
   assign burst_go = burst && start == '0;
   assign done_now = busy && tick && left == LW'(1);
   assign launch   = (!busy && (burst_go || sw_go)) || (done_now && burst_go);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         start_q   <= '0;
         left      <= '0;
         res_q     <= '0;
         held      <= '0;
         cur_chan  <= '0;
         res_valid <= 1'b0;
         res_data  <= '0;
         res_chan  <= '0;
      end else begin
         start_q   <= start;
         res_valid <= done_now;
         if (done_now) begin
            res_data <= held >> res_q;
            res_chan <= cur_chan;
         end
         if (launch) begin
            st       <= ST_CONV;
            cur_chan <= pick;
            left     <= LW'(conv_clocks(SW, int'(res)));
            res_q    <= res;
            held     <= ain[int'(pick)*SW +: SW];
         end else if (done_now) begin
            st <= ST_IDLE;
         end else if (busy && tick) begin
            left <= left - 1'b1;
         end
      end
   end

   // R5: bits above the kept width are zero in a presented result
   a_r5_lsb_align: assert property (@(posedge clk) disable iff (!rst_n)
      done_now |=> ((res_data >> conv_bits(SW, int'($past(res_q)))) == '0));

   // R8: a burst with a non-zero start code never leaves idle
   a_r8_start_block: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && burst && start != '0) |=> !busy);

   // R9: once burst is off, a finishing conversion leaves the block idle
   a_r9_stop_drain: assert property (@(posedge clk) disable iff (!rst_n)
      (done_now && !burst) |=> !busy);

   // R10: the channel stays put for the whole conversion
   a_r10_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done_now) |=> (busy && $stable(cur_chan)));

   // R4: the remaining-clock count never exceeds the longest conversion
   a_r4_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (int'(left) >= 1 && int'(left) <= SW + 1));

endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
   parameter int NCH = 8,
   localparam int CHW = $clog2(NCH)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           valid,
   input  logic [CHW-1:0] chan,
   input  logic [NCH-1:0] clr,
   output logic [NCH-1:0] done,
   output logic [NCH-1:0] ovr
);
   for (genvar c = 0; c < NCH; c++) begin : g_slot
      logic hit;
      assign hit = valid && (chan == CHW'(c));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            done[c] <= 1'b0;
            ovr[c]  <= 1'b0;
         end else if (hit) begin
            done[c] <= 1'b1;
            ovr[c]  <= clr[c] ? 1'b0 : (ovr[c] | done[c]);
         end else if (clr[c]) begin
            done[c] <= 1'b0;
            ovr[c]  <= 1'b0;
         end
      end

      // R11: a result landing on an unread slot raises overrun
      a_r11_overrun: assert property (@(posedge clk) disable iff (!rst_n)
         (hit && done[c] && !clr[c]) |=> ovr[c]);

      // R11: overrun is only ever present alongside done
      a_r11_ovr_implies_done: assert property (@(posedge clk) disable iff (!rst_n)
         ovr[c] |-> done[c]);
   end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
   parameter int NCH  = 8,
   parameter int SW   = 10,
   parameter int DIVW = 8,
   parameter int RESW = 3,
   parameter int STW  = 3,
   localparam int CHW = $clog2(NCH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NCH-1:0]    ctrl_mask,
   input  logic [DIVW-1:0]   ctrl_div,
   input  logic              ctrl_burst,
   input  logic [RESW-1:0]   ctrl_res,
   input  logic [STW-1:0]    ctrl_start,
   input  logic [NCH*SW-1:0] ain,
   input  logic [NCH-1:0]    rd_clr,
   output logic              conv_tick,
   output logic              busy,
   output logic [CHW-1:0]    cur_chan,
   output logic              res_valid,
   output logic [SW-1:0]     res_data,
   output logic [CHW-1:0]    res_chan,
   output logic [NCH-1:0]    done_flags,
   output logic [NCH-1:0]    ovr_flags
);
   if (NCH < 2)            $error("NCH must be at least 2");
   if (SW < (1 << RESW))   $error("SW too small for every resolution code");
   if (DIVW < 1)           $error("DIVW must be at least 1");
   if (STW < 1)            $error("STW must be at least 1");

   logic [CHW-1:0] pick;

   adc_clk_div #(.DIVW(DIVW)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .div  (ctrl_div),
      .tick (conv_tick)
   );

   adc_chan_pick #(.NCH(NCH)) u_pick (
      .mask (ctrl_mask),
      .prev (cur_chan),
      .first(!busy),
      .pick (pick)
   );

   adc_conv_core #(.NCH(NCH), .SW(SW), .RESW(RESW), .STW(STW)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (conv_tick),
      .burst    (ctrl_burst),
      .res      (ctrl_res),
      .start    (ctrl_start),
      .ain      (ain),
      .pick     (pick),
      .busy     (busy),
      .cur_chan (cur_chan),
      .res_valid(res_valid),
      .res_data (res_data),
      .res_chan (res_chan)
   );

   adc_result_bank #(.NCH(NCH)) u_bank (
      .clk  (clk),
      .rst_n(rst_n),
      .valid(res_valid),
      .chan (res_chan),
      .clr  (rd_clr),
      .done (done_flags),
      .ovr  (ovr_flags)
   );

   // R1: nothing is presented or flagged in the cycle after reset
   a_r1_quiet_reset: assert property (@(posedge clk)
      $rose(rst_n) |-> (!res_valid && done_flags == '0 && ovr_flags == '0));

endmodule

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  ctrl_mask = '0;
   logic [7:0]  ctrl_div = '0;
   logic        ctrl_burst = 1'b0;
   logic [2:0]  ctrl_res = '0;
   logic [2:0]  ctrl_start = '0;
   logic [79:0] ain;
   logic [7:0]  rd_clr = '0;
   logic        conv_tick, busy, res_valid;
   logic [2:0]  cur_chan, res_chan;
   logic [9:0]  res_data;
   logic [7:0]  done_flags, ovr_flags;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   adc_scan_seq dut (
      .clk(clk), .rst_n(rst_n), .ctrl_mask(ctrl_mask), .ctrl_div(ctrl_div),
      .ctrl_burst(ctrl_burst), .ctrl_res(ctrl_res), .ctrl_start(ctrl_start),
      .ain(ain), .rd_clr(rd_clr), .conv_tick(conv_tick), .busy(busy),
      .cur_chan(cur_chan), .res_valid(res_valid), .res_data(res_data),
      .res_chan(res_chan), .done_flags(done_flags), .ovr_flags(ovr_flags)
   );

   function automatic logic [9:0] samp(input int c);
      return 10'(10'h2A5 ^ (c * 37));
   endfunction

   initial begin
      for (int c = 0; c < 8; c++) ain[c*10 +: 10] = samp(c);
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // counts falling edges until res_valid is seen; lim+1 if never
   task automatic wait_valid(output int k, input int lim);
      k = 0;
      do begin
         @(negedge clk);
         k++;
      end while (!res_valid && k <= lim);
   endtask

   task automatic quiet(input string req, input int n);
      int seen = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (res_valid) seen++;
      end
      check({req, " no result"}, seen, 0);
      check({req, " idle"}, int'(busy), 0);
   endtask

   task automatic sw_start(input logic [7:0] m, input logic [2:0] r);
      ctrl_start = 3'b000;
      ctrl_mask  = m;
      ctrl_res   = r;
      @(negedge clk);
      ctrl_start = 3'b001;
   endtask

   task automatic stop_burst();
      int k;
      ctrl_burst = 1'b0;
      k = 0;
      while (busy && k < 200) begin
         @(negedge clk);
         k++;
      end
      @(negedge clk);
   endtask

   task automatic t_reset();
      check("R1 busy", int'(busy), 0);
      check("R1 valid", int'(res_valid), 0);
      check("R1 data", int'(res_data), 0);
      check("R1 chan", int'(cur_chan), 0);
      check("R1 done", int'(done_flags), 0);
      check("R1 ovr", int'(ovr_flags), 0);
   endtask

   task automatic t_sw_full();
      int k;
      sw_start(8'h08, 3'd0);
      wait_valid(k, 40);
      check("R4 length code0", k, 12);
      check("R3 channel", int'(res_chan), 3);
      check("R5 data code0", int'(res_data), int'(samp(3)));
      @(negedge clk);
      check("R11 done set", int'(done_flags), 8'h08);
   endtask

   task automatic t_sw_short_and_hold();
      int k;
      sw_start(8'h40, 3'd7);
      wait_valid(k, 40);
      check("R4 length code7", k, 5);
      check("R3 lowest of mask", int'(res_chan), 6);
      check("R5 data code7", int'(res_data), int'(samp(6) >> 7));
      quiet("R12 held start", 30);
   endtask

   task automatic t_busy_start();
      int k;
      int extra = 0;
      sw_start(8'h02, 3'd0);
      @(negedge clk);
      @(negedge clk);
      ctrl_start = 3'b000;
      @(negedge clk);
      ctrl_start = 3'b001;
      wait_valid(k, 40);
      check("R12 first result chan", int'(res_chan), 1);
      for (int i = 0; i < 30; i++) begin
         @(negedge clk);
         if (res_valid) extra++;
      end
      check("R12 start while busy ignored", extra, 0);
   endtask

   task automatic t_overrun();
      int k;
      sw_start(8'h08, 3'd2);
      wait_valid(k, 40);
      @(negedge clk);
      check("R11 overrun set", int'(ovr_flags[3]), 1);
      rd_clr = 8'h08;
      @(negedge clk);
      rd_clr = 8'h00;
      check("R11 clear done", int'(done_flags[3]), 0);
      check("R11 clear ovr", int'(ovr_flags[3]), 0);
      ctrl_start = 3'b000;
   endtask

   task automatic t_burst_scan();
      int k;
      int exp_ch[4] = '{2, 5, 7, 2};
      ctrl_start = 3'b000;
      ctrl_mask  = 8'hA4;
      ctrl_res   = 3'd0;
      ctrl_burst = 1'b1;
      wait_valid(k, 40);
      check("R6 first chan", int'(res_chan), exp_ch[0]);
      for (int i = 1; i < 4; i++) begin
         wait_valid(k, 40);
         check("R6 scan chan", int'(res_chan), exp_ch[i]);
         check("R4 burst spacing", k, 11);
         check("R5 burst data", int'(res_data), int'(samp(exp_ch[i])));
      end
      ctrl_burst = 1'b0;
      wait_valid(k, 40);
      check("R9 in-flight result chan", int'(res_chan), 5);
      quiet("R9 after stop", 30);
   endtask

   task automatic t_mask_change();
      int k;
      int exp_ch[3] = '{2, 7, 0};
      ctrl_mask  = 8'h04;
      ctrl_burst = 1'b1;
      wait_valid(k, 40);
      check("R10 first chan", int'(res_chan), 2);
      ctrl_mask = 8'h81;
      for (int i = 0; i < 3; i++) begin
         wait_valid(k, 40);
         check("R10 chan after mask change", int'(res_chan), exp_ch[i]);
      end
      stop_burst();
   endtask

   task automatic t_empty_mask();
      int k;
      ctrl_mask  = 8'h00;
      ctrl_burst = 1'b1;
      for (int i = 0; i < 2; i++) begin
         wait_valid(k, 40);
         check("R7 empty mask chan", int'(res_chan), 0);
      end
      stop_burst();
   endtask

   task automatic t_start_block();
      int k;
      ctrl_mask  = 8'h10;
      ctrl_start = 3'b010;
      ctrl_burst = 1'b1;
      quiet("R8 nonzero start", 30);
      ctrl_start = 3'b000;
      wait_valid(k, 40);
      check("R8 scan after start zero", int'(res_chan), 4);
      stop_burst();
   endtask

   task automatic t_divider();
      int k;
      int ticks = 0;
      ctrl_div = 8'd3;
      @(negedge clk);
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (conv_tick) ticks++;
      end
      check("R2 ticks in 40 cycles", ticks, 10);
      sw_start(8'h20, 3'd7);
      wait_valid(k, 80);
      check("R2 divided length in window", int'((k - 1) >= 13 && (k - 1) <= 16), 1);
      check("R3 divided chan", int'(res_chan), 5);
      ctrl_start = 3'b000;
      ctrl_div   = 8'd0;
   endtask

   initial begin
      #(10 * 100000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sw_full();
      t_sw_short_and_hold();
      t_busy_start();
      t_overrun();
      t_burst_scan();
      t_mask_change();
      t_empty_mask();
      t_start_block();
      t_divider();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule